// File: doc/BRIEF.md
# Deferred-Preset Lag Accumulator

This block keeps the 40-bit integral (lag) accumulator of a carrier tracking loop filter and lets a host preset it without disturbing an in-progress filter update. In every compute cycle, marked by a one-clock start strobe, the accumulator adds a sign-extended 24-bit error sample. The host stages a 32-bit preset value in four byte-wide staging registers on a small register bus. A write to a trigger address then arms a preset.

An armed preset is not applied at once. It waits for the next compute-cycle strobe. On that strobe the staged word fills the upper 32 bits of the accumulator, the lower 8 bits are cleared, and the normal accumulation for that cycle is skipped. A status bit drops when a preset is armed and rises once the preset value is present in the accumulator. Software polls this bit before it stages the next value.

Top module: `lagacc_init_top`

## Requirements
- R1: After reset the accumulator is zero, every staging register reads zero, the status byte reads zero, and no preset is armed.
- R2: In a clock with `cyc_start` low, `acc_out` does not change.
- R3: On a clock with `cyc_start` high and no preset armed, `acc_out` becomes the old value plus `err_in` sign-extended from bit 23, modulo 2^40.
- R4: A bus write to address 0, 1, 2 or 3 stores the byte in staging register 0 to 3. Reading that address returns it. Register 0 is bits 7:0 of the preset word and register 3 is bits 31:24.
- R5: A bus write to address 4 arms a preset and leaves `acc_out` unchanged until the next `cyc_start`.
- R6: On the first `cyc_start` clock with a preset armed, `acc_out` becomes {reg3, reg2, reg1, reg0, 8'h00}. `err_in` is ignored on that clock and the preset is disarmed.
- R7: The preset uses the staging contents as they stand before the strobe clock. A staging write in the same clock as the strobe goes to the register but not into that preset.
- R8: Reading address 5 returns {7'b0, done}. done clears on the clock of a trigger write and reads 1 from the first cycle in which the preset value is visible on `acc_out`.
- R9: A trigger write in the same clock as `cyc_start` does not affect that strobe, which accumulates. The preset lands on the following strobe.
- R10: A trigger write in the clock where an armed preset lands lets that preset apply, arms a new one, and leaves done at 0.
- R11: Reading any address other than 0 to 5 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_rdaddr | input | 4 | Read address (combinational read) |
| bus_rdata | output | 8 | Read data |
| cyc_start | input | 1 | Compute-cycle start strobe |
| err_in | input | 24 | Signed loop error sample |
| acc_out | output | 40 | Lag accumulator value |

## Verification
The collisions of interest are a compute-cycle strobe in the same clock as a trigger write, and a strobe in the same clock as a staging-register write. The bench drives each of these together with a strobe, both when a preset is armed and when none is. A reference model applies the strobe against the state that stood before the clock and applies the bus write after it. From that it predicts whether the strobe accumulates or presets, which staging byte is loaded, and the status bit, and it compares these with the design's results one clock later.

// File: rtl/lagacc_pkg.sv
package lagacc_pkg;
   // Bus address map (behavioural: the bench and host rely on these)
   localparam int unsigned STAGE_ADDR_LAST = 3;
   localparam int unsigned TRIG_ADDR       = 4;
   localparam int unsigned STAT_ADDR       = 5;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_ACCUM = 2'd1,
      ACT_LOAD  = 2'd2
   } acc_action_e;
endpackage

// File: rtl/lagacc_stage_regs.sv
module lagacc_stage_regs #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned WORD_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [WORD_W-1:0] word
);
   genvar b;
   generate
      for (b = 0; b < NBYTES; b++) begin : g_byte
         logic [BYTE_W-1:0] r_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               r_q <= '0;
            else if (wr && (addr == ADDR_W'(b)))
               r_q <= wdata;
         end
         assign word[b*BYTE_W +: BYTE_W] = r_q;
      end
   endgenerate
endmodule

// File: rtl/lagacc_load_ctrl.sv
module lagacc_load_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_wr,
   input  logic cyc_start,
   output logic pend,
   output logic done,
   output logic load_now
);
   assign load_now = pend & cyc_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         done <= 1'b0;
      end else begin
         if (trig_wr)
            pend <= 1'b1;
         else if (load_now)
            pend <= 1'b0;

         if (trig_wr)
            done <= 1'b0;
         else if (load_now)
            done <= 1'b1;
      end
   end
endmodule

// File: rtl/lagacc_accum.sv
module lagacc_accum
   import lagacc_pkg::*;
#(
   parameter int unsigned ACC_W  = 40,
   parameter int unsigned LOAD_W = 32,
   parameter int unsigned ERR_W  = 24,
   localparam int unsigned LOW_W = ACC_W - LOAD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic              load_now,
   input  logic [LOAD_W-1:0] load_val,
   input  logic [ERR_W-1:0]  err_in,
   output logic [ACC_W-1:0]  acc_q
);
   logic [ACC_W-1:0] err_ext;
   acc_action_e      act;

   generate
      if (ERR_W < ACC_W) begin : g_sext
         assign err_ext = {{(ACC_W-ERR_W){err_in[ERR_W-1]}}, err_in};
      end else begin : g_full
         assign err_ext = err_in[ACC_W-1:0];
      end
   endgenerate

   always_comb begin
      if (load_now)
         act = ACT_LOAD;
      else if (cyc_start)
         act = ACT_ACCUM;
      else
         act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else begin
         case (act)
            ACT_LOAD:  acc_q <= {load_val, {LOW_W{1'b0}}};
            ACT_ACCUM: acc_q <= acc_q + err_ext;
            default:   acc_q <= acc_q;
         endcase
      end
   end
endmodule

// File: rtl/lagacc_init_top.sv
module lagacc_init_top
   import lagacc_pkg::*;
#(
   parameter int unsigned ACC_W  = 40,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 4,
   parameter int unsigned ERR_W  = 24,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned LOAD_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_rdaddr,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              cyc_start,
   input  logic [ERR_W-1:0]  err_in,
   output logic [ACC_W-1:0]  acc_out
);
   generate
      if (LOAD_W >= ACC_W) begin : g_bad_load
         $error("staging word must be narrower than the accumulator");
      end
      if (ERR_W > ACC_W) begin : g_bad_err
         $error("error input wider than accumulator");
      end
      if ((1 << ADDR_W) <= STAT_ADDR || NBYTES != STAGE_ADDR_LAST + 1) begin : g_bad_map
         $error("address map does not fit the parameters");
      end
   endgenerate

   logic              trig_wr;
   logic              load_pend;
   logic              done_flag;
   logic              load_now;
   logic [LOAD_W-1:0] stage_word;

   assign trig_wr = bus_wr && (bus_addr == ADDR_W'(TRIG_ADDR));

   lagacc_stage_regs #(
      .BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .word(stage_word)
   );

   lagacc_load_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .cyc_start(cyc_start),
      .pend(load_pend), .done(done_flag), .load_now(load_now)
   );

   lagacc_accum #(
      .ACC_W(ACC_W), .LOAD_W(LOAD_W), .ERR_W(ERR_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .load_now(load_now),
      .load_val(stage_word), .err_in(err_in), .acc_q(acc_out)
   );

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (bus_rdaddr == ADDR_W'(i))
            bus_rdata = stage_word[i*BYTE_W +: BYTE_W];
      end
      if (bus_rdaddr == ADDR_W'(STAT_ADDR))
         bus_rdata = {{(BYTE_W-1){1'b0}}, done_flag};
   end
endmodule

// File: rtl/lagacc_chk.sv
module lagacc_chk #(
   parameter int unsigned ACC_W  = 40,
   parameter int unsigned LOAD_W = 32,
   parameter int unsigned ERR_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_wr,
   input logic              cyc_start,
   input logic [ERR_W-1:0]  err_in,
   input logic [ACC_W-1:0]  acc_out,
   input logic              load_pend,
   input logic              done_flag,
   input logic [LOAD_W-1:0] stage_word
);
   localparam int unsigned LOW_W = ACC_W - LOAD_W;
   logic [ACC_W-1:0] err_wide;
   assign err_wide = ACC_W'($signed(err_in));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(acc_out));
   // R3
   accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !load_pend) |=> acc_out == $past(acc_out) + $past(err_wide));
   // R6
   preset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && load_pend) |=> acc_out == {$past(stage_word), {LOW_W{1'b0}}});
   // R5
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> load_pend);
   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> !done_flag);
   // R8
   status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(cyc_start && load_pend));
endmodule

bind lagacc_init_top lagacc_chk #(
   .ACC_W(ACC_W), .LOAD_W(LOAD_W), .ERR_W(ERR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .cyc_start(cyc_start),
   .err_in(err_in), .acc_out(acc_out), .load_pend(load_pend),
   .done_flag(done_flag), .stage_word(stage_word)
);

// File: tb/tb_lagacc_init_top.sv
module tb_lagacc_init_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [3:0]  bus_rdaddr = 4'd5;
   logic [7:0]  bus_rdata;
   logic        cyc_start = 1'b0;
   logic [23:0] err_in = '0;
   logic [39:0] acc_out;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [39:0] acc;
      logic [7:0]  stat;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   // reference model state
   logic [39:0] m_acc = '0;
   logic [7:0]  m_stage [4] = '{default: 8'h00};
   bit          m_pend = 0;
   bit          m_done = 0;

   lagacc_init_top dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdaddr(bus_rdaddr), .bus_rdata(bus_rdata),
      .cyc_start(cyc_start), .err_in(err_in), .acc_out(acc_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: compares one result per driven clock
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (acc_out !== e.acc) begin
            errors++;
            $display("FAIL %s acc: actual %h expected %h", e.tag, acc_out, e.acc);
         end
         checks++;
         if (bus_rdata !== e.stat) begin
            errors++;
            $display("FAIL %s status: actual %h expected %h", e.tag, bus_rdata, e.stat);
         end
      end
   end

   // driver: one clock of stimulus, model updated, expectation queued
   task automatic cyc(input bit strb, input logic [23:0] err,
                      input bit we, input logic [3:0] wa, input logic [7:0] wd,
                      input string tag);
      @(negedge clk);
      cyc_start = strb; err_in = err;
      bus_wr = we; bus_addr = wa; bus_wdata = wd;
      if (strb) begin
         if (m_pend) begin
            m_acc  = {m_stage[3], m_stage[2], m_stage[1], m_stage[0], 8'h00};
            m_pend = 0;
            m_done = 1;
         end else begin
            m_acc = m_acc + {{16{err[23]}}, err};
         end
      end
      if (we && wa < 4) m_stage[wa[1:0]] = wd;
      if (we && wa == 4) begin
         m_pend = 1;
         m_done = 0;
      end
      @(posedge clk);
      exp_q.push_back('{m_acc, {7'b0, m_done}, tag});
   endtask

   task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_rdaddr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, bus_rdata, exp);
      end
      bus_rdaddr = 4'd5;
   endtask

   task automatic idle_out();
      cyc(0, '0, 0, '0, '0, "drain");
      @(negedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      cyc(0, 24'h0, 0, 0, 0, "R1");
      idle_out();
      for (int i = 0; i < 4; i++) rd_check(4'(i), 8'h00, "R1");

      // R3: accumulate positive, negative, large
      cyc(1, 24'h000010, 0, 0, 0, "R3");
      cyc(1, 24'hFFFFF0, 0, 0, 0, "R3");
      cyc(1, 24'h7FFFFF, 0, 0, 0, "R3");
      cyc(1, 24'h800000, 0, 0, 0, "R3");
      // R2: no strobe, error ignored
      cyc(0, 24'h000123, 0, 0, 0, "R2");
      cyc(0, 24'h7FFFFF, 0, 0, 0, "R2");

      // R4: staging writes
      cyc(0, 0, 1, 4'd0, 8'h11, "R4");
      cyc(0, 0, 1, 4'd1, 8'h22, "R4");
      cyc(0, 0, 1, 4'd2, 8'h33, "R4");
      cyc(0, 0, 1, 4'd3, 8'h44, "R4");

      // R5: trigger arms, nothing moves yet
      cyc(0, 24'h000005, 1, 4'd4, 8'h00, "R5");
      cyc(0, 24'h000005, 0, 0, 0, "R5");
      // R6/R8: preset lands, error ignored, done set
      cyc(1, 24'h000005, 0, 0, 0, "R6");
      cyc(1, 24'h000001, 0, 0, 0, "R3");

      // R7: write before strobe counts; write with strobe does not
      cyc(0, 0, 1, 4'd4, 8'h00, "R8");
      cyc(0, 0, 1, 4'd3, 8'h55, "R7");
      cyc(1, 24'h000009, 1, 4'd0, 8'hAA, "R7");
      cyc(0, 0, 0, 0, 0, "R7");

      // R9: trigger in the same clock as a strobe
      cyc(1, 24'h000002, 1, 4'd4, 8'h00, "R9");
      cyc(1, 24'h000003, 0, 0, 0, "R9");

      // R10: re-arm on the landing clock
      cyc(0, 0, 1, 4'd4, 8'h00, "R10");
      cyc(1, 24'h000004, 1, 4'd4, 8'h00, "R10");
      cyc(0, 0, 1, 4'd1, 8'h77, "R10");
      cyc(1, 24'h000004, 0, 0, 0, "R10");

      // R3: wrap modulo 2^40 after an all-ones preset
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 4'(i), 8'hFF, "R4");
      cyc(0, 0, 1, 4'd4, 8'h00, "R5");
      cyc(1, 0, 0, 0, 0, "R6");
      cyc(1, 24'h000200, 0, 0, 0, "R3");
      cyc(1, 24'hFFFFFF, 0, 0, 0, "R3");

      // R4 readback with distinct bytes, R11 unmapped address
      cyc(0, 0, 1, 4'd0, 8'hA0, "R4");
      cyc(0, 0, 1, 4'd2, 8'hC2, "R4");
      idle_out();
      rd_check(4'd0, 8'hA0, "R4");
      rd_check(4'd1, 8'hFF, "R4");
      rd_check(4'd2, 8'hC2, "R4");
      rd_check(4'd3, 8'hFF, "R4");
      rd_check(4'd5, 8'h01, "R8");
      rd_check(4'd7, 8'h00, "R11");
      rd_check(4'd15, 8'h00, "R11");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule